// File: doc/BRIEF.md
# Isochronous Cycle Timing Monitor

This block sits beside the link layer of a serial bus that carries isochronous traffic. It keeps a local cycle timer made of three fields: a sub-cycle offset, a cycle number and a seconds count. It watches the bus events that the link reports: cycle starts received, the start of this node's own cycle-start transmission, subaction gaps and arbitration reset gaps. From these it raises five kinds of one-clock event pulses. Two are periodic: a new cycle has begun, and the top seconds bit has flipped. Three are anomalies: a cycle ran too long while this node was cycle master, a received cycle number disagreed with the local timer, and an expected cycle start never arrived.

Each pulse is meant to drive the set input of one bit of an interrupt event register. The timer advances on a tick enable that runs at the nominal 24.576 MHz. When the node is not cycle master, every received cycle start loads its cycle number into the local timer. This load happens after the consistency comparison, so the comparison uses the old value.

Top module: `cycle_timing_monitor`

## Requirements
- R1: The offset field advances by one on each clock with `tick_i` high. It counts from 0 to OFF_LIMIT-1 and then returns to 0. On that wrap the cycle number advances by one.
- R2: The cycle number counts from 0 to CNT_LIMIT-1 and then returns to 0. That wrap advances the SEC_W-bit seconds count by one, and the seconds count wraps at its full width.
- R3: `ev_sync_o` pulses for one clock whenever bit 0 of the cycle number changes, whether by counting or by loading. The pulse comes on the clock after the tick or load that caused the change.
- R4: `ev_sec64_o` pulses for one clock whenever the most significant seconds bit changes. With the bench parameters this is first after 64·CNT_LIMIT·OFF_LIMIT ticks from reset.
- R5: `ev_inconsistent_o` pulses on the clock after `cs_rx_i` when `cs_rx_count_i` differs from the local cycle number held before that strobe.
- R6: While `cyc_master_i` is low, `cs_rx_i` loads `cs_rx_count_i` into the cycle number. While it is high, a received cycle start leaves the cycle number unchanged.
- R7: While `cyc_master_i` is high, `cs_tx_start_i` starts a tick count. If no `sub_gap_i` arrives, `ev_too_long_o` pulses exactly once, on the clock after the LONG_TICKS-th tick that follows the start.
- R8: A `sub_gap_i` that arrives before that tick cancels the count, and no too-long pulse follows.
- R9: With `cyc_master_i` low, `cs_tx_start_i` starts nothing, and no too-long pulse follows.
- R10: After a sync event, detection waits for the first `sub_gap_i`. If the next event after that gap is another `sub_gap_i` or an `arb_gap_i` rather than a cycle start, `ev_lost_o` pulses on the following clock. A cycle start here means `cs_rx_i` or `cs_tx_start_i`.
- R11: After a sync event, an `arb_gap_i` that arrives before any cycle start pulses `ev_lost_o` on the following clock.
- R12: After a lost pulse, or after a cycle start seen while armed, detection is idle. Gaps then raise nothing until the next sync event.
- R13: During and right after reset, all event outputs are low and all timer fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 24.576 MHz timer tick enable |
| cyc_master_i | input | 1 | This node is cycle master |
| cs_rx_i | input | 1 | Cycle-start packet received strobe |
| cs_rx_count_i | input | CNT_W | Cycle number carried by the received cycle start |
| cs_tx_start_i | input | 1 | Start of this node's cycle-start transmission |
| sub_gap_i | input | 1 | Subaction gap detected |
| arb_gap_i | input | 1 | Arbitration reset gap detected |
| ev_too_long_o | output | 1 | Cycle-too-long event pulse |
| ev_inconsistent_o | output | 1 | Cycle-number mismatch event pulse |
| ev_lost_o | output | 1 | Cycle-lost event pulse |
| ev_sync_o | output | 1 | New-cycle event pulse |
| ev_sec64_o | output | 1 | Top-seconds-bit change event pulse |

## Verification
Every event output is registered, so each pulse is due exactly one clock after the edge that samples its cause. The cause is a tick, a received cycle start, or a gap strobe. The lost detector arms one clock later still, on the clock where the sync pulse is visible. For that reason the vectors place an idle cycle between a cycle-number load and the gap that tests it. The bench drives each stimulus on a falling edge and checks the outputs on the next falling edge. Each tick-counting test compares the pulse with the exact tick index at which it is due, so a pulse that comes one tick early or late is reported.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    typedef enum logic [1:0] {
        LS_IDLE  = 2'd0,
        LS_ARMED = 2'd1,
        LS_GAP   = 2'd2
    } lost_state_e;

endpackage

// File: rtl/ctm_cycle_timer.sv
module ctm_cycle_timer #(
    parameter int OFF_LIMIT = 3072,
    parameter int CNT_LIMIT = 8000,
    parameter int CNT_W     = 13,
    parameter int SEC_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sync_o,
    output logic             sec64_o
);
    localparam int OFF_W = $clog2(OFF_LIMIT);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_LIMIT - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_LIMIT - 1);

    typedef struct packed {
        logic [OFF_W-1:0] offset;
        logic [CNT_W-1:0] count;
        logic [SEC_W-1:0] secs;
        logic             sync;
        logic             sec64;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d       = tmr_q;
        tmr_d.sync  = 1'b0;
        tmr_d.sec64 = 1'b0;
        if (tick_i) begin
            if (tmr_q.offset == OFF_LAST) begin
                tmr_d.offset = '0;
                if (tmr_q.count == CNT_LAST) begin
                    tmr_d.count = '0;
                    tmr_d.secs  = tmr_q.secs + 1'b1;
                end else begin
                    tmr_d.count = tmr_q.count + 1'b1;
                end
            end else begin
                tmr_d.offset = tmr_q.offset + 1'b1;
            end
        end
        if (load_i) begin
            tmr_d.count = load_val_i;
        end
        tmr_d.sync  = tmr_d.count[0] ^ tmr_q.count[0];
        tmr_d.sec64 = tmr_d.secs[SEC_W-1] ^ tmr_q.secs[SEC_W-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign count_o = tmr_q.count;
    assign sync_o  = tmr_q.sync;
    assign sec64_o = tmr_q.sec64;

    // R1: a tick below the last offset moves the offset up by exactly one
    a_r1_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && tmr_q.offset != OFF_LAST) |=> tmr_q.offset == $past(tmr_q.offset) + 1'b1);

    // R2: with neither tick nor load, the cycle number holds
    a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(tmr_q.count));

    // R3: a sync pulse always has a tick or a load behind it
    a_r3_sync_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> $past(tick_i || load_i));

    // R4: the top seconds bit only moves when the lower seconds bits are zero
    a_r4_sec64_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        sec64_o |-> tmr_q.secs[SEC_W-2:0] == '0);

endmodule

// File: rtl/ctm_long_watch.sv
module ctm_long_watch #(
    parameter int LONG_TICKS = 2888
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic master_i,
    input  logic tx_start_i,
    input  logic sub_gap_i,
    output logic too_long_o
);
    localparam int LT_W = $clog2(LONG_TICKS + 1);
    localparam logic [LT_W-1:0] LT_LAST = LT_W'(LONG_TICKS - 1);

    typedef struct packed {
        logic            active;
        logic [LT_W-1:0] ticks;
        logic            fire;
    } lw_t;

    lw_t lw_d, lw_q;

    always_comb begin
        lw_d      = lw_q;
        lw_d.fire = 1'b0;
        if (!master_i) begin
            lw_d.active = 1'b0;
            lw_d.ticks  = '0;
        end else if (tx_start_i) begin
            lw_d.active = 1'b1;
            lw_d.ticks  = '0;
        end else if (lw_q.active) begin
            if (sub_gap_i) begin
                lw_d.active = 1'b0;
            end else if (tick_i) begin
                if (lw_q.ticks == LT_LAST) begin
                    lw_d.fire   = 1'b1;
                    lw_d.active = 1'b0;
                end else begin
                    lw_d.ticks = lw_q.ticks + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lw_q <= '0;
        end else begin
            lw_q <= lw_d;
        end
    end

    assign too_long_o = lw_q.fire;

    // R7: the too-long event is a single pulse per started cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        too_long_o |=> !too_long_o);

    // R9: the watch is idle whenever this node is not cycle master
    a_r9_idle_slave: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |=> (!lw_q.active && !too_long_o));

    // R8: a subaction gap during a running watch stops it without an event
    a_r8_gap_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (lw_q.active && sub_gap_i && !tx_start_i) |=> !too_long_o);

endmodule

// File: rtl/ctm_lost_detect.sv
module ctm_lost_detect
    import ctm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic cyc_start_i,
    input  logic sub_gap_i,
    input  logic arb_gap_i,
    output logic lost_o
);
    typedef struct packed {
        lost_state_e st;
        logic        lost;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d      = ld_q;
        ld_d.lost = 1'b0;
        if (sync_i) begin
            ld_d.st = LS_ARMED;
        end else begin
            unique case (ld_q.st)
                LS_ARMED: begin
                    if (cyc_start_i) begin
                        ld_d.st = LS_IDLE;
                    end else if (arb_gap_i) begin
                        ld_d.st   = LS_IDLE;
                        ld_d.lost = 1'b1;
                    end else if (sub_gap_i) begin
                        ld_d.st = LS_GAP;
                    end
                end
                LS_GAP: begin
                    if (cyc_start_i) begin
                        ld_d.st = LS_IDLE;
                    end else if (arb_gap_i || sub_gap_i) begin
                        ld_d.st   = LS_IDLE;
                        ld_d.lost = 1'b1;
                    end
                end
                default: ld_d.st = LS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q <= '{st: LS_IDLE, lost: 1'b0};
        end else begin
            ld_q <= ld_d;
        end
    end

    assign lost_o = ld_q.lost;

    // R12: a lost event only comes out of an armed detector
    a_r12_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |-> $past(ld_q.st != LS_IDLE));

    // R12: in idle, gaps never produce a lost event
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_q.st == LS_IDLE && !sync_i) |=> !lost_o);

    // R11: an arbitration reset gap while armed always reports a lost cycle
    a_r11_arb_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_q.st != LS_IDLE && !sync_i && !cyc_start_i && arb_gap_i) |=> lost_o);

endmodule

// File: rtl/cycle_timing_monitor.sv
module cycle_timing_monitor #(
    parameter int OFF_LIMIT  = 3072,
    parameter int CNT_LIMIT  = 8000,
    parameter int CNT_W      = 13,
    parameter int SEC_W      = 7,
    parameter int LONG_TICKS = 2888
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cyc_master_i,
    input  logic             cs_rx_i,
    input  logic [CNT_W-1:0] cs_rx_count_i,
    input  logic             cs_tx_start_i,
    input  logic             sub_gap_i,
    input  logic             arb_gap_i,
    output logic             ev_too_long_o,
    output logic             ev_inconsistent_o,
    output logic             ev_lost_o,
    output logic             ev_sync_o,
    output logic             ev_sec64_o
);
    logic [CNT_W-1:0] cycle_count;
    logic             load_en;
    logic             sync_ev;
    logic             incons_d, incons_q;

    assign load_en = cs_rx_i && !cyc_master_i;

    ctm_cycle_timer #(
        .OFF_LIMIT (OFF_LIMIT),
        .CNT_LIMIT (CNT_LIMIT),
        .CNT_W     (CNT_W),
        .SEC_W     (SEC_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (load_en),
        .load_val_i (cs_rx_count_i),
        .count_o    (cycle_count),
        .sync_o     (sync_ev),
        .sec64_o    (ev_sec64_o)
    );

    ctm_long_watch #(
        .LONG_TICKS (LONG_TICKS)
    ) u_long (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .master_i   (cyc_master_i),
        .tx_start_i (cs_tx_start_i),
        .sub_gap_i  (sub_gap_i),
        .too_long_o (ev_too_long_o)
    );

    ctm_lost_detect u_lost (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_ev),
        .cyc_start_i (cs_rx_i || cs_tx_start_i),
        .sub_gap_i   (sub_gap_i),
        .arb_gap_i   (arb_gap_i),
        .lost_o      (ev_lost_o)
    );

    always_comb begin
        incons_d = cs_rx_i && (cs_rx_count_i != cycle_count);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            incons_q <= 1'b0;
        end else begin
            incons_q <= incons_d;
        end
    end

    assign ev_inconsistent_o = incons_q;
    assign ev_sync_o         = sync_ev;

    // R5: a mismatch pulse always follows a received cycle start
    a_r5_needs_rx: assert property (@(posedge clk) disable iff (!rst_n)
        ev_inconsistent_o |-> $past(cs_rx_i));

    // R6: as cycle master, a received cycle start does not move the cycle number
    a_r6_master_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rx_i && cyc_master_i && !tick_i) |=> $stable(cycle_count));

    // R6: as non-master, a received cycle start takes effect on the next clock
    a_r6_slave_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cycle_count == $past(cs_rx_count_i));

endmodule

// File: tb/sim_cycle_timing_monitor.sv
module sim_cycle_timing_monitor;
    localparam int OFF_L  = 8;
    localparam int CNT_L  = 16;
    localparam int CW     = 13;
    localparam int SW     = 7;
    localparam int LONG_T = 20;
    localparam int NVEC   = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0, master = 1'b0, rx = 1'b0, txs = 1'b0;
    logic          sgap = 1'b0, agap = 1'b0;
    logic [CW-1:0] rxcnt = '0;
    logic          e_long, e_inc, e_lost, e_sync, e_s64;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cycle_timing_monitor #(
        .OFF_LIMIT (OFF_L), .CNT_LIMIT (CNT_L), .CNT_W (CW),
        .SEC_W (SW), .LONG_TICKS (LONG_T)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .tick_i (tick), .cyc_master_i (master),
        .cs_rx_i (rx), .cs_rx_count_i (rxcnt), .cs_tx_start_i (txs),
        .sub_gap_i (sgap), .arb_gap_i (agap),
        .ev_too_long_o (e_long), .ev_inconsistent_o (e_inc), .ev_lost_o (e_lost),
        .ev_sync_o (e_sync), .ev_sec64_o (e_s64)
    );

    // {master, rx, count[12:0], sub_gap, arb_gap, exp_incons, exp_lost, exp_sync}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 13'd0,  1'b0, 1'b0, 3'b000},  // consistent, no load change
        {1'b0, 1'b1, 13'd5,  1'b0, 1'b0, 3'b101},  // R5 R6 R3 load 5
        {1'b0, 1'b0, 13'd0,  1'b0, 1'b0, 3'b000},  // arm
        {1'b0, 1'b0, 13'd0,  1'b1, 1'b0, 3'b000},  // first gap
        {1'b0, 1'b1, 13'd5,  1'b0, 1'b0, 3'b000},  // cycle start in time
        {1'b0, 1'b1, 13'd6,  1'b0, 1'b0, 3'b101},
        {1'b0, 1'b0, 13'd0,  1'b0, 1'b0, 3'b000},
        {1'b0, 1'b0, 13'd0,  1'b1, 1'b0, 3'b000},
        {1'b0, 1'b0, 13'd0,  1'b1, 1'b0, 3'b010},  // R10 second gap -> lost
        {1'b0, 1'b0, 13'd0,  1'b1, 1'b0, 3'b000},  // R12 idle
        {1'b0, 1'b1, 13'd7,  1'b0, 1'b0, 3'b101},
        {1'b0, 1'b0, 13'd0,  1'b0, 1'b0, 3'b000},
        {1'b0, 1'b0, 13'd0,  1'b0, 1'b1, 3'b010},  // R11 arb gap while armed
        {1'b0, 1'b1, 13'd8,  1'b0, 1'b0, 3'b101},
        {1'b0, 1'b0, 13'd0,  1'b0, 1'b0, 3'b000},
        {1'b0, 1'b1, 13'd8,  1'b0, 1'b0, 3'b000},  // start seen while armed
        {1'b0, 1'b0, 13'd0,  1'b0, 1'b1, 3'b000},  // R12 idle after start
        {1'b0, 1'b1, 13'd9,  1'b0, 1'b0, 3'b101},
        {1'b0, 1'b0, 13'd0,  1'b0, 1'b0, 3'b000},
        {1'b0, 1'b0, 13'd0,  1'b1, 1'b0, 3'b000},
        {1'b0, 1'b0, 13'd0,  1'b0, 1'b1, 3'b010},  // R10 arb gap after first gap
        {1'b0, 1'b1, 13'd11, 1'b0, 1'b0, 3'b100},  // R3 lsb unchanged, no sync
        {1'b1, 1'b1, 13'd3,  1'b0, 1'b0, 3'b100},  // R6 master, no load
        {1'b1, 1'b1, 13'd11, 1'b0, 1'b0, 3'b000}   // R6 count still 11
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic t, input logic m, input logic r, input logic [CW-1:0] c,
                         input logic x, input logic s, input logic a);
        tick = t; master = m; rx = r; rxcnt = c; txs = x; sgap = s; agap = a;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(0, 0, 0, '0, 0, 0, 0);
        drive(0, 0, 0, '0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 60000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int first_pulse;
        int pulses;
        @(negedge clk);
        do_reset();
        // R13 reset state
        chk("R13 long",   e_long, 1'b0);
        chk("R13 incons", e_inc,  1'b0);
        chk("R13 lost",   e_lost, 1'b0);
        chk("R13 sync",   e_sync, 1'b0);
        chk("R13 sec64",  e_s64,  1'b0);

        for (int i = 0; i < NVEC; i++) begin
            drive(0, VEC[i][19], VEC[i][18], VEC[i][17:5], 0, VEC[i][4], VEC[i][3]);
            chk("R5 vec incons", e_inc,  VEC[i][2]);
            chk("R10 vec lost",  e_lost, VEC[i][1]);
            chk("R3 vec sync",   e_sync, VEC[i][0]);
        end

        // R13 count zero after reset: consistent receive of 0 as master
        do_reset();
        drive(0, 1, 1, 13'd0, 0, 0, 0);
        chk("R13 count zero", e_inc, 1'b0);

        // R1 R3 sync every OFF_L ticks
        do_reset();
        for (int i = 1; i <= 3 * OFF_L; i++) begin
            drive(1, 1, 0, '0, 0, 0, 0);
            chk("R1 sync cadence", e_sync, (i % OFF_L) == 0);
        end

        // R2 R4 top seconds bit after 64 seconds of ticks
        do_reset();
        first_pulse = 0;
        pulses = 0;
        for (int i = 1; i <= 64 * CNT_L * OFF_L + 20; i++) begin
            drive(1, 1, 0, '0, 0, 0, 0);
            if (e_s64) begin
                pulses++;
                if (first_pulse == 0) first_pulse = i;
            end
        end
        n_chk++;
        if (first_pulse != 64 * CNT_L * OFF_L) begin
            n_fail++;
            $display("FAIL R4 first sec64 tick: actual %0d expected %0d", first_pulse, 64 * CNT_L * OFF_L);
        end
        n_chk++;
        if (pulses != 1) begin
            n_fail++;
            $display("FAIL R2 sec64 pulse count: actual %0d expected 1", pulses);
        end

        // R7 too long fires on the LONG_T-th tick, once
        do_reset();
        drive(0, 1, 0, '0, 1, 0, 0);
        chk("R7 no pulse at start", e_long, 1'b0);
        for (int i = 1; i <= LONG_T + 10; i++) begin
            drive(1, 1, 0, '0, 0, 0, 0);
            chk("R7 too long timing", e_long, i == LONG_T);
        end

        // R8 subaction gap before threshold cancels
        drive(0, 1, 0, '0, 1, 0, 0);
        for (int i = 1; i <= LONG_T / 2; i++) drive(1, 1, 0, '0, 0, 0, 0);
        drive(0, 1, 0, '0, 0, 1, 0);
        for (int i = 1; i <= LONG_T + 5; i++) begin
            drive(1, 1, 0, '0, 0, 0, 0);
            chk("R8 cancelled", e_long, 1'b0);
        end

        // R9 not cycle master: no watch
        drive(0, 0, 0, '0, 1, 0, 0);
        for (int i = 1; i <= LONG_T + 5; i++) begin
            drive(1, 0, 0, '0, 0, 0, 0);
            chk("R9 slave quiet", e_long, 1'b0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule